// File: doc/BRIEF.md
# Blink Plane Selector and Hex Decoder

This block sits in the segment path of a multiplexed LED display driver. Each display digit owns two stored bytes, one in each of two data planes. For the digit that the scan logic presents at any moment, the block chooses which plane's byte is shown. It then turns that byte into eight segment enables. The byte either passes through the hexadecimal font or goes straight to the segment lines, as that digit's decode bit selects.

Blinking works by switching between whole planes rather than by gating segments. A blink timebase counts ticks of the multiplex clock. It flips a registered phase bit after every half-period, and the half-period comes from a slow or a fast rate parameter. While blinking is enabled, phase 0 shows plane 0 and phase 1 shows plane 1. While it is disabled, only plane 0 is used. A sync pulse puts the timebase back to the start of a period, so that several units written together stay in phase.

Scan sequencing and brightness modulation belong to neighbouring blocks.

Top module: `blink_glyph_unit`

## Requirements
- R1: While reset is asserted and just after it is released, `blink_phase` is 0 and `seg_out` is 8'h00.
- R2: When `blink_en` is 0, the shown byte is `plane0_byte`, and `plane1_byte` has no effect on `seg_out`, whatever the blink phase.
- R3: When `blink_en` is 1, the shown byte is `plane0_byte` while the phase is 0 and `plane1_byte` while the phase is 1.
- R4: The timebase advances only on a clock edge where `mux_tick` is 1. `blink_phase` toggles on the tick that completes a half-period, which is SLOW_HALF ticks when `blink_fast` is 0 and FAST_HALF ticks when it is 1.
- R5: A change of `blink_fast` partway through a half-period does not shorten or lengthen that half-period. The new length applies from the next half-period boundary.
- R6: `blink_sync` clears the tick count and sets the phase to 0 on the next edge. It also loads the half-period length selected at that moment, and it wins over a coincident `mux_tick`, including one at a terminal count.
- R7: With decode on, bits 3:0 pick a hex glyph and bits 6:4 are ignored. Bit 7 drives the decimal point, active high.
- R8: Segment order on `seg_out` is bit 7 = dp, bit 6 = a, bit 5 = b, bit 4 = c, bit 3 = d, bit 2 = e, bit 1 = f, bit 0 = g. With decode off, the byte maps onto this order unchanged.
- R9: Decode is chosen per digit: bit `digit_idx` of `decode_mask` decides for the digit being shown.
- R10: A zero byte shows the glyph for 0 (8'h7E) with decode on and shows all segments dark (8'h00) with decode off.
- R11: `seg_out` is registered: it reflects the inputs and the phase present one clock edge earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mux_tick | input | 1 | One-cycle enable marking a multiplex-clock tick |
| blink_sync | input | 1 | Pulse that restarts the blink timebase |
| blink_en | input | 1 | Enables alternation between the two planes |
| blink_fast | input | 1 | 1 selects the fast half-period, 0 the slow one |
| digit_idx | input | IDX_W | Index of the digit being scanned |
| plane0_byte | input | 8 | Stored byte of that digit in plane 0 |
| plane1_byte | input | 8 | Stored byte of that digit in plane 1 |
| decode_mask | input | NUM_DIGITS | Per-digit hex decode enables |
| seg_out | output | 8 | Registered segment enables, dp then a to g |
| blink_phase | output | 1 | Registered blink phase, 0 = first half |

## Verification
A sync pulse and a terminal-count tick can land on the same clock edge. So can a change of rate and a half-period boundary. The bench counts ticks up to one short of the end of a half-period, then drives `blink_sync` and `mux_tick` together. It expects the phase to stay at 0 rather than toggle, and the next half-period to run its full length. It also flips `blink_fast` in the middle of a half-period. A scoreboard model predicts the phase and segments edge by edge from the requirements, and it judges both the old-length finish of that half-period and the new length after it.

// File: rtl/blink_glyph_pkg.sv
package blink_glyph_pkg;

    typedef logic [7:0] seg_byte_t;

    // Hex glyph in a..g order (bit 6 = a, bit 0 = g)
    function automatic logic [6:0] hex_glyph(input logic [3:0] nib);
        logic [6:0] g;
        case (nib)
            4'h0: g = 7'b1111110;
            4'h1: g = 7'b0110000;
            4'h2: g = 7'b1101101;
            4'h3: g = 7'b1111001;
            4'h4: g = 7'b0110011;
            4'h5: g = 7'b1011011;
            4'h6: g = 7'b1011111;
            4'h7: g = 7'b1110000;
            4'h8: g = 7'b1111111;
            4'h9: g = 7'b1111011;
            4'hA: g = 7'b1110111;
            4'hB: g = 7'b0011111;
            4'hC: g = 7'b1001110;
            4'hD: g = 7'b0111101;
            4'hE: g = 7'b1001111;
            default: g = 7'b1000111;
        endcase
        return g;
    endfunction

endpackage

// File: rtl/blink_timebase.sv
module blink_timebase #(
    parameter int SLOW_HALF = 4000000,
    parameter int FAST_HALF = 2000000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic sync,
    input  logic fast,
    output logic phase
);
    localparam int MAX_HALF = (SLOW_HALF > FAST_HALF) ? SLOW_HALF : FAST_HALF;
    localparam int CNT_W = $clog2(MAX_HALF + 1);
    localparam logic [CNT_W-1:0] SLOW_L = CNT_W'(SLOW_HALF);
    localparam logic [CNT_W-1:0] FAST_L = CNT_W'(FAST_HALF);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] lim;
        logic             ph;
    } tb_state_t;

    tb_state_t st_d, st_q;
    logic [CNT_W-1:0] rate_sel;

    always_comb begin
        st_d     = st_q;
        rate_sel = fast ? FAST_L : SLOW_L;
        if (sync) begin
            st_d.cnt = '0;
            st_d.ph  = 1'b0;
            st_d.lim = rate_sel;
        end else if (tick) begin
            if (st_q.cnt == st_q.lim - CNT_W'(1)) begin
                st_d.cnt = '0;
                st_d.ph  = ~st_q.ph;
                st_d.lim = rate_sel;
            end else begin
                st_d.cnt = st_q.cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.cnt <= '0;
            st_q.lim <= SLOW_L;
            st_q.ph  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign phase = st_q.ph;

    // R4: count never reaches the active half-period length
    a_r4_cnt_below_limit: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt < st_q.lim);

    // R4: phase only moves on a tick or a sync
    a_r4_phase_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !sync) |=> $stable(st_q.ph));

    // R5: half-period length is held while a half-period is in progress
    a_r5_limit_held_midway: assert property (@(posedge clk) disable iff (!rst_n)
        (!sync && st_q.cnt != st_q.lim - CNT_W'(1)) |=> $stable(st_q.lim));

    // R6: sync restarts at phase 0
    a_r6_sync_zero_phase: assert property (@(posedge clk) disable iff (!rst_n)
        sync |=> (st_q.ph == 1'b0 && st_q.cnt == '0));

endmodule

// File: rtl/plane_select.sv
module plane_select
    import blink_glyph_pkg::*;
(
    input  logic      blink_en,
    input  logic      phase,
    input  seg_byte_t p0_byte,
    input  seg_byte_t p1_byte,
    output seg_byte_t shown_byte
);
    always_comb begin
        shown_byte = (blink_en && phase) ? p1_byte : p0_byte;
    end
endmodule

// File: rtl/glyph_decoder.sv
module glyph_decoder
    import blink_glyph_pkg::*;
(
    input  seg_byte_t raw_byte,
    input  logic      dec_on,
    output seg_byte_t seg_vec
);
    always_comb begin
        if (dec_on) begin
            seg_vec = {raw_byte[7], hex_glyph(raw_byte[3:0])};
        end else begin
            seg_vec = raw_byte;
        end
    end
endmodule

// File: rtl/blink_glyph_unit.sv
module blink_glyph_unit
    import blink_glyph_pkg::*;
#(
    parameter int NUM_DIGITS = 8,
    parameter int SLOW_HALF  = 4000000,
    parameter int FAST_HALF  = 2000000,
    localparam int IDX_W     = (NUM_DIGITS > 1) ? $clog2(NUM_DIGITS) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  mux_tick,
    input  logic                  blink_sync,
    input  logic                  blink_en,
    input  logic                  blink_fast,
    input  logic [IDX_W-1:0]      digit_idx,
    input  logic [7:0]            plane0_byte,
    input  logic [7:0]            plane1_byte,
    input  logic [NUM_DIGITS-1:0] decode_mask,
    output logic [7:0]            seg_out,
    output logic                  blink_phase
);
    typedef struct packed {
        seg_byte_t seg;
    } out_state_t;

    out_state_t o_d, o_q;
    logic       phase_w;
    logic       dec_bit;
    seg_byte_t  sel_byte;
    seg_byte_t  glyph_w;

    blink_timebase #(
        .SLOW_HALF(SLOW_HALF),
        .FAST_HALF(FAST_HALF)
    ) u_timebase (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (mux_tick),
        .sync (blink_sync),
        .fast (blink_fast),
        .phase(phase_w)
    );

    plane_select u_sel (
        .blink_en  (blink_en),
        .phase     (phase_w),
        .p0_byte   (plane0_byte),
        .p1_byte   (plane1_byte),
        .shown_byte(sel_byte)
    );

    always_comb begin
        dec_bit = decode_mask[digit_idx];
    end

    glyph_decoder u_dec (
        .raw_byte(sel_byte),
        .dec_on  (dec_bit),
        .seg_vec (glyph_w)
    );

    always_comb begin
        o_d     = o_q;
        o_d.seg = glyph_w;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            o_q.seg <= '0;
        end else begin
            o_q <= o_d;
        end
    end

    assign seg_out     = o_q.seg;
    assign blink_phase = phase_w;

    // R2: blink disabled, raw digit shows plane 0 one edge later
    a_r2_plane0_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!blink_en && !dec_bit) |=> seg_out == $past(plane0_byte));

    // R3: blink enabled in phase 1, raw digit shows plane 1 one edge later
    a_r3_plane1_in_phase1: assert property (@(posedge clk) disable iff (!rst_n)
        (blink_en && blink_phase && !dec_bit) |=> seg_out == $past(plane1_byte));

    // R7: decimal point follows bit 7 of the chosen byte when decoding
    a_r7_dp_follows_bit7: assert property (@(posedge clk) disable iff (!rst_n)
        dec_bit |=> seg_out[7] == $past(sel_byte[7]));

endmodule

// File: tb/blink_glyph_unit_bench.sv
module blink_glyph_unit_bench;
    localparam int CLK_P = 10;
    localparam int ND    = 8;
    localparam int SLOWH = 6;
    localparam int FASTH = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mux_tick = 1'b0, blink_sync = 1'b0, blink_en = 1'b0, blink_fast = 1'b0;
    logic [2:0] digit_idx = '0;
    logic [7:0] plane0_byte = '0, plane1_byte = '0;
    logic [ND-1:0] decode_mask = '0;
    logic [7:0] seg_out;
    logic       blink_phase;

    int n_cmp = 0;
    int n_bad = 0;

    logic [8:0] exp_q[$];
    string      tag_q[$];

    // bench model of the timebase
    int   m_cnt = 0;
    int   m_lim = SLOWH;
    logic m_ph  = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    blink_glyph_unit #(
        .NUM_DIGITS(ND),
        .SLOW_HALF (SLOWH),
        .FAST_HALF (FASTH)
    ) u_blink_glyph_unit (
        .clk        (clk),
        .rst_n      (rst_n),
        .mux_tick   (mux_tick),
        .blink_sync (blink_sync),
        .blink_en   (blink_en),
        .blink_fast (blink_fast),
        .digit_idx  (digit_idx),
        .plane0_byte(plane0_byte),
        .plane1_byte(plane1_byte),
        .decode_mask(decode_mask),
        .seg_out    (seg_out),
        .blink_phase(blink_phase)
    );

    function automatic logic [6:0] font_ref(input logic [3:0] v);
        logic [6:0] r;
        case (v)
            4'h0: r = 7'h7E; 4'h1: r = 7'h30; 4'h2: r = 7'h6D; 4'h3: r = 7'h79;
            4'h4: r = 7'h33; 4'h5: r = 7'h5B; 4'h6: r = 7'h5F; 4'h7: r = 7'h70;
            4'h8: r = 7'h7F; 4'h9: r = 7'h7B; 4'hA: r = 7'h77; 4'hB: r = 7'h1F;
            4'hC: r = 7'h4E; 4'hD: r = 7'h3D; 4'hE: r = 7'h4F; default: r = 7'h47;
        endcase
        return r;
    endfunction

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // driver: applies one cycle of stimulus and pushes the expected result
    task automatic step(input logic tk, input logic sy, input logic en, input logic fs,
                        input int idx, input logic [7:0] b0, input logic [7:0] b1,
                        input logic [ND-1:0] mask, input string tag);
        logic       ph_before;
        logic [7:0] sel;
        logic [7:0] seg_exp;
        @(negedge clk);
        mux_tick = tk; blink_sync = sy; blink_en = en; blink_fast = fs;
        digit_idx = 3'(idx); plane0_byte = b0; plane1_byte = b1; decode_mask = mask;
        ph_before = m_ph;
        if (sy) begin
            m_cnt = 0; m_ph = 1'b0; m_lim = fs ? FASTH : SLOWH;
        end else if (tk) begin
            if (m_cnt == m_lim - 1) begin
                m_cnt = 0; m_ph = ~m_ph; m_lim = fs ? FASTH : SLOWH;
            end else begin
                m_cnt = m_cnt + 1;
            end
        end
        sel = (en && ph_before) ? b1 : b0;
        seg_exp = mask[idx] ? {sel[7], font_ref(sel[3:0])} : sel;
        exp_q.push_back({m_ph, seg_exp});
        tag_q.push_back(tag);
    endtask

    // monitor: pops and compares after each edge
    initial begin
        forever begin
            @(posedge clk);
            #(CLK_P/4);
            if (exp_q.size() > 0) begin
                logic [8:0] e;
                string      t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                n_cmp++;
                if ({blink_phase, seg_out} !== e) begin
                    n_bad++;
                    $display("FAIL %s: phase/seg actual %b/%h expected %b/%h",
                             t, blink_phase, seg_out, e[8], e[7:0]);
                end
            end
        end
    end

    initial begin
        #(CLK_P * 100000);
        n_bad++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1: reset state
        n_cmp++;
        if (blink_phase !== 1'b0 || seg_out !== 8'h00) begin
            n_bad++;
            $display("FAIL R1: phase/seg actual %b/%h expected 0/00", blink_phase, seg_out);
        end
        rst_n = 1'b1;
        @(negedge clk);
        n_cmp++;
        if (blink_phase !== 1'b0 || seg_out !== 8'h00) begin
            n_bad++;
            $display("FAIL R1: after release actual %b/%h expected 0/00", blink_phase, seg_out);
        end

        // R2 / R8: blink off, raw bytes, phase allowed to run
        for (int i = 0; i < 16; i++)
            step(1'b1, 1'b0, 1'b0, 1'b0, i % ND, 8'hA5 ^ 8'(i), 8'h5A, '0, "R2");
        step(1'b0, 1'b0, 1'b0, 1'b0, 2, 8'h80, 8'hFF, '0, "R8");
        step(1'b0, 1'b0, 1'b0, 1'b0, 2, 8'h01, 8'hFF, '0, "R8");

        // R7: all nibbles, junk in bits 6:4, dp alternating
        for (int v = 0; v < 16; v++)
            step(1'b0, 1'b0, 1'b0, 1'b0, 5, {v[0], 3'b101, 4'(v)}, 8'h00, 8'h20, "R7");

        // R9: per-digit decode selection
        for (int d = 0; d < ND; d++)
            step(1'b0, 1'b0, 1'b0, 1'b0, d, 8'h06, 8'h00, 8'h0A, "R9");

        // R10: cleared byte
        step(1'b0, 1'b0, 1'b0, 1'b0, 1, 8'h00, 8'h00, 8'h02, "R10");
        step(1'b0, 1'b0, 1'b0, 1'b0, 1, 8'h00, 8'h00, 8'h00, "R10");

        // R11: an input change shows after exactly one edge
        step(1'b0, 1'b0, 1'b0, 1'b0, 0, 8'h3C, 8'h00, 8'h00, "R11");
        step(1'b0, 1'b0, 1'b0, 1'b0, 0, 8'hC3, 8'h00, 8'h00, "R11");

        // R3 / R4: blink on, slow rate, tick every cycle
        step(1'b0, 1'b1, 1'b1, 1'b0, 4, 8'h81, 8'h18, '0, "R6");
        for (int i = 0; i < 14; i++)
            step(1'b1, 1'b0, 1'b1, 1'b0, 4, 8'h81, 8'h18, 8'h01, "R3");
        // R4: sparse ticks
        for (int i = 0; i < 16; i++)
            step(i[0], 1'b0, 1'b1, 1'b0, 3, 8'h0F, 8'hF0, '0, "R4");
        // R4: fast rate
        step(1'b0, 1'b1, 1'b1, 1'b1, 3, 8'h0F, 8'hF0, '0, "R4");
        for (int i = 0; i < 8; i++)
            step(1'b1, 1'b0, 1'b1, 1'b1, 3, 8'h0F, 8'hF0, '0, "R4");

        // R5: rate flipped partway through a slow half-period
        step(1'b0, 1'b1, 1'b1, 1'b0, 6, 8'h55, 8'hAA, '0, "R5");
        step(1'b1, 1'b0, 1'b1, 1'b0, 6, 8'h55, 8'hAA, '0, "R5");
        step(1'b1, 1'b0, 1'b1, 1'b0, 6, 8'h55, 8'hAA, '0, "R5");
        for (int i = 0; i < 12; i++)
            step(1'b1, 1'b0, 1'b1, 1'b1, 6, 8'h55, 8'hAA, '0, "R5");

        // R6: sync in phase 1, then sync with tick at terminal count
        step(1'b0, 1'b1, 1'b1, 1'b1, 7, 8'hE0, 8'h07, 8'h00, "R6");
        for (int i = 0; i < 4; i++)
            step(1'b1, 1'b0, 1'b1, 1'b1, 7, 8'hE0, 8'h07, 8'h00, "R6");
        step(1'b0, 1'b1, 1'b1, 1'b1, 7, 8'hE0, 8'h07, 8'h00, "R6");
        step(1'b1, 1'b0, 1'b1, 1'b1, 7, 8'hE0, 8'h07, 8'h00, "R6");
        step(1'b1, 1'b0, 1'b1, 1'b1, 7, 8'hE0, 8'h07, 8'h00, "R6");
        step(1'b1, 1'b1, 1'b1, 1'b1, 7, 8'hE0, 8'h07, 8'h00, "R6");
        for (int i = 0; i < 7; i++)
            step(1'b1, 1'b0, 1'b1, 1'b1, 7, 8'hE0, 8'h07, 8'h80, "R6");

        step(1'b0, 1'b0, 1'b0, 1'b0, 0, 8'h00, 8'h00, '0, "R2");
        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule